// File: doc/BRIEF.md
# Supply Supervisor with Watchdog Reset

This block supervises a processor from inside a clocked design. It receives a synchronous power-good indication and a watchdog input driven by software. It produces an active-low processor reset and the active-high complement of that reset. When power-good goes low, reset is asserted at once. When power-good returns, reset is stretched for a fixed reset time before it is released.

Once reset is released, a watchdog window opens. Software must make the watchdog input change level, in either direction, before the timeout elapses. If no change arrives in time, the block issues a reset pulse of the same reset time. A status flag goes low on that timeout and returns high at the next change of the watchdog input. While the input stays at a constant level, reset pulses repeat with a period of the reset time plus the timeout.

A separate input marks the watchdog input as floating, and this disables the watchdog. All durations are given in milliseconds and converted to clock cycles from the clock-frequency parameter. A single counter times both the stretch and the watchdog window.

Top module: `supply_supervisor`

## Requirements
- R1: When power_good is sampled low at a clock edge, reset_n is 0 after that edge and stays 0 for as long as power_good stays low.
- R2: After power_good is sampled high again, reset_n stays 0 for exactly RST_CYC cycles following that edge and then goes to 1. A power_good drop during the stretch restarts the full stretch.
- R3: With reset released and no watchdog-input change, reset_n stays 1 for exactly TMO_CYC cycles, and then a reset pulse of exactly RST_CYC cycles is issued.
- R4: With wdi held constant, the timeout pulses repeat indefinitely with a period of TMO_CYC high cycles plus RST_CYC low cycles.
- R5: wdi passes through a two-flop synchronizer. Each change, rising or falling, restarts the timeout. A change sampled d cycles after release (0 ≤ d ≤ TMO_CYC−3) gives a released period of d+TMO_CYC+3 cycles.
- R6: wdo goes to 0 on the same edge at which a timeout asserts reset, and it stays 0 while wdi is unchanged.
- R7: A wdi change returns wdo to 1 within four cycles, even during a reset pulse. A change during a pulse does not shorten the pulse or move the following timeout, which is counted from release.
- R8: While power_good is low, wdo is 1.
- R9: While wdi_float is 1, no timeout reset occurs and wdo is 1.
- R10: reset_hi is always the exact complement of reset_n.
- R11: The synchronous active-high rst returns the block to reset asserted (reset_n 0) with wdo 1 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block reset |
| power_good | input | 1 | Synchronous supply-good indication |
| wdi | input | 1 | Watchdog input from software, asynchronous |
| wdi_float | input | 1 | 1 = watchdog input floating, watchdog disabled |
| reset_n | output | 1 | Active-low processor reset |
| reset_hi | output | 1 | Active-high processor reset |
| wdo | output | 1 | Watchdog status, 0 after a timeout |

## Verification
The bench sweeps the cycle in which a wdi change lands across the whole watchdog window, up to three cycles before expiry. It checks the exact length of each released period. A design that let the timeout win over a late edge, or that lost a synchronizer stage, would be off by one or would pulse reset early. Power glitches of one to four cycles, including one during the stretch, must each produce a full stretch; a counter that resumed instead of restarting would release reset too early. A wdi change inside a reset pulse must raise wdo without moving the next timeout, and wdo must be forced high while power is lost even after a timeout has dropped it. A design that shared the edge path between status and timing would fail one of these checks.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } sup_state_e;

    typedef struct packed {
        logic clear;
        logic inc;
    } tmr_cmd_t;

    typedef struct packed {
        logic timeout;
        logic wd_edge;
    } wd_evt_t;

    function automatic int unsigned ms_to_cycles(input longint unsigned hz,
                                                 input longint unsigned ms);
        longint unsigned c;
        c = (hz * ms) / 64'd1000;
        if (c < 64'd4) c = 64'd4;
        return int'(c);
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sup_wdi_sync.sv
module sup_wdi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wdi,
    output logic wd_edge
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= wdi;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[i] <= 1'b0;
                    else     sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[STAGES-1];
    end

    assign wd_edge = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/sup_timer.sv
module sup_timer
    import sup_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  tmr_cmd_t     cmd,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || cmd.clear)  count_q <= '0;
        else if (cmd.inc)      count_q <= count_q + 1'b1;
    end

    assign done = (count_q == limit - 1'b1);
endmodule

// File: rtl/sup_ctrl.sv
module sup_ctrl
    import sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       power_good,
    input  logic       wd_edge,
    input  logic       wdi_float,
    input  logic       tmr_done,
    output tmr_cmd_t   cmd,
    output sup_state_e state,
    output logic       wdo
);
    sup_state_e state_q, state_d;
    wd_evt_t    evt;
    logic       wdo_q;

    always_comb begin
        state_d     = state_q;
        cmd.clear   = 1'b0;
        cmd.inc     = 1'b1;
        evt.timeout = 1'b0;
        evt.wd_edge = wd_edge;
        unique case (state_q)
            ST_HOLD: begin
                cmd.clear = 1'b1;
                if (power_good) state_d = ST_STRETCH;
            end
            ST_STRETCH: begin
                if (tmr_done) begin
                    state_d   = ST_RUN;
                    cmd.clear = 1'b1;
                end
            end
            ST_RUN: begin
                if (wdi_float || wd_edge) begin
                    cmd.clear = 1'b1;
                end else if (tmr_done) begin
                    state_d     = ST_STRETCH;
                    cmd.clear   = 1'b1;
                    evt.timeout = 1'b1;
                end
            end
            default: begin
                state_d   = ST_HOLD;
                cmd.clear = 1'b1;
            end
        endcase
        if (!power_good) begin
            state_d     = ST_HOLD;
            cmd.clear   = 1'b1;
            evt.timeout = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
            wdo_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            if (!power_good || wdi_float) wdo_q <= 1'b1;
            else if (evt.timeout)         wdo_q <= 1'b0;
            else if (evt.wd_edge)         wdo_q <= 1'b1;
        end
    end

    assign state = state_q;
    assign wdo   = wdo_q;
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
    import sup_pkg::*;
#(
    parameter longint unsigned CLK_HZ     = 1_000_000,
    parameter longint unsigned RESET_MS   = 140,
    parameter longint unsigned TIMEOUT_MS = 1600,
    parameter int              SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic power_good,
    input  logic wdi,
    input  logic wdi_float,
    output logic reset_n,
    output logic reset_hi,
    output logic wdo
);
    localparam int unsigned RST_CYC = ms_to_cycles(CLK_HZ, RESET_MS);
    localparam int unsigned TMO_CYC = ms_to_cycles(CLK_HZ, TIMEOUT_MS);
    localparam int          W       = $clog2(max_u(RST_CYC, TMO_CYC) + 1);

    logic         wd_edge;
    logic         tmr_done;
    tmr_cmd_t     cmd;
    sup_state_e   state;
    logic [W-1:0] limit;

    sup_wdi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .wdi     (wdi),
        .wd_edge (wd_edge)
    );

    assign limit = (state == ST_RUN) ? W'(TMO_CYC) : W'(RST_CYC);

    sup_timer #(.W(W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .limit (limit),
        .done  (tmr_done)
    );

    sup_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .power_good (power_good),
        .wd_edge    (wd_edge),
        .wdi_float  (wdi_float),
        .tmr_done   (tmr_done),
        .cmd        (cmd),
        .state      (state),
        .wdo        (wdo)
    );

    assign reset_n  = (state == ST_RUN);
    assign reset_hi = ~reset_n;
endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
    parameter int unsigned RST_CYC = 4
) (
    input logic clk,
    input logic rst,
    input logic power_good,
    input logic wdi_float,
    input logic reset_n,
    input logic reset_hi,
    input logic wdo
);
    logic [31:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || reset_n || !power_good) low_run <= '0;
        else                               low_run <= low_run + 1;
    end

    AST_PG_HOLDS_RESET: assert property (@(posedge clk) disable iff (rst)
        !power_good |=> !reset_n);                                   // R1

    AST_STRETCH_MIN: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_n) |-> (low_run >= RST_CYC));                     // R2

    AST_WDO_FALL_WITH_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(wdo) |-> $fell(reset_n));                               // R6

    AST_WDO_PG_HIGH: assert property (@(posedge clk) disable iff (rst)
        !power_good |=> wdo);                                         // R8

    AST_FLOAT_NO_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        (wdi_float && power_good && reset_n) |=> reset_n);            // R9

    AST_RST_CLEARS: assert property (@(posedge clk)
        rst |=> (!reset_n && wdo));                                   // R11

    AST_COMPLEMENT_STABLE: assert property (@(posedge clk) disable iff (rst)
        $stable(reset_n) |-> $stable(reset_hi));                      // R10
endmodule

bind supply_supervisor sup_checker #(.RST_CYC(RST_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .power_good (power_good),
    .wdi_float  (wdi_float),
    .reset_n    (reset_n),
    .reset_hi   (reset_hi),
    .wdo        (wdo)
);

// File: tb/supply_supervisor_test.sv
module supply_supervisor_test;
    localparam int R = 6;
    localparam int T = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic power_good = 1'b0;
    logic wdi = 1'b0;
    logic wdi_float = 1'b0;
    logic reset_n, reset_hi, wdo;

    int n_tests = 0;
    int n_fail  = 0;
    int comp_err = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    supply_supervisor #(
        .CLK_HZ(1000), .RESET_MS(R), .TIMEOUT_MS(T)
    ) uut (
        .clk(clk), .rst(rst), .power_good(power_good), .wdi(wdi),
        .wdi_float(wdi_float), .reset_n(reset_n), .reset_hi(reset_hi), .wdo(wdo)
    );

    always @(negedge clk) if (!rst && reset_hi !== ~reset_n) comp_err++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_level(input logic lvl, output int n);
        n = 0;
        while (reset_n == lvl && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic toggle();
        wdi = ~wdi;
    endtask

    int n;
    int bad;

    initial begin
        repeat (3) @(negedge clk);
        // R11 / R10: reset state
        check(reset_n == 1'b0, "R11 reset_n in rst", int'(reset_n), 0);
        check(wdo == 1'b1, "R11 wdo in rst", int'(wdo), 1);
        check(reset_hi == 1'b1, "R10 reset_hi in rst", int'(reset_hi), 1);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(reset_n == 1'b0, "R1 held while power low", int'(reset_n), 0);

        // R2: power-up stretch
        power_good = 1'b1;
        @(negedge clk);
        count_level(1'b0, n);
        check(n == R, "R2 power-up stretch", n, R);

        // R3 / R4 / R6: repeating timeouts with constant wdi
        for (int k = 0; k < 3; k++) begin
            count_level(1'b1, n);
            check(n == T, "R3 released window", n, T);
            check(wdo == 1'b0, "R6 wdo low at timeout", int'(wdo), 0);
            count_level(1'b0, n);
            check(n == R, "R4 repeated pulse width", n, R);
        end
        check(wdo == 1'b0, "R6 wdo stays low", int'(wdo), 0);

        // R8: power drop forces wdo high
        power_good = 1'b0;
        @(negedge clk);
        check(reset_n == 1'b0, "R1 reset on power drop", int'(reset_n), 0);
        check(wdo == 1'b1, "R8 wdo forced high", int'(wdo), 1);

        // R2: glitch sweep, including drop during stretch
        for (int g = 1; g <= 4; g++) begin
            power_good = 1'b1;
            repeat (2) @(negedge clk);
            power_good = 1'b0;
            repeat (g) @(negedge clk);
            check(reset_n == 1'b0, "R1 held during glitch", int'(reset_n), 0);
            power_good = 1'b1;
            @(negedge clk);
            count_level(1'b0, n);
            check(n == R, "R2 stretch after glitch", n, R);
            count_level(1'b1, n);
            count_level(1'b0, n);
        end

        // R5: sweep toggle position across the window
        for (int d = 0; d <= T - 3; d++) begin
            count_level(1'b1, n);
            count_level(1'b0, n);
            // now at the first released sample
            repeat (d) @(negedge clk);
            toggle();
            count_level(1'b1, n);
            check(n == T + 3, "R5 window restart", n + d, d + T + 3);
        end

        // R5: keep-alive toggling of both polarities
        count_level(1'b0, n);
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            toggle();
            repeat (T - 5) begin
                @(negedge clk);
                if (!reset_n) bad++;
            end
        end
        check(bad == 0, "R5 keep-alive no reset", bad, 0);

        // R7: edge during pulse raises wdo, timing unchanged
        count_level(1'b1, n);
        check(wdo == 1'b0, "R6 wdo low before edge", int'(wdo), 0);
        toggle();
        repeat (4) @(negedge clk);
        check(wdo == 1'b1, "R7 wdo raised by edge", int'(wdo), 1);
        count_level(1'b0, n);
        check(n == R - 4, "R7 pulse not shortened", n, R - 4);
        count_level(1'b1, n);
        check(n == T, "R7 timeout from release", n, T);

        // R9: floating watchdog input
        count_level(1'b0, n);
        wdi_float = 1'b1;
        bad = 0;
        repeat (3 * T) begin
            @(negedge clk);
            if (!reset_n || !wdo) bad++;
        end
        check(bad == 0, "R9 float disables watchdog", bad, 0);
        wdi_float = 1'b0;

        // R11: block reset mid-run
        rst = 1'b1;
        @(negedge clk);
        check(reset_n == 1'b0 && wdo == 1'b1, "R11 rst mid-run",
              int'({reset_n, wdo}), 1);
        rst = 1'b0;

        check(comp_err == 0, "R10 complement", comp_err, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule